// File: doc/BRIEF.md
# Interrupt Aggregator with Message Signalling

This block gathers eleven interrupt request lines from a peripheral bus bridge into a single processor notification. It does not drive an interrupt wire. When an enabled input changes, the block records the change in a request register that clears when read. It then posts one bus write whose address and payload both come from a programmable 32-bit target register. The block also exposes the raw, synchronised level of every line. Software can therefore rescan lines that are still asserted after it has serviced the recorded changes, which emulates level-triggered behaviour.

Software reaches the block through a simple register port. A read returns its data one cycle after the request. Reading the request register returns the latched changes and clears them in the same access. The notification leaves through a valid/ready write channel and stays stable until it is accepted.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset the mask, request, pending and level registers read zero and `msg_valid` is low.
- R2: Only request bits in the implemented set 0x5FF (bits 0 to 8 and bit 10) can be recorded or written into the mask. Bit 9 and all bits above 10 read as zero in the request and mask registers.
- R3: A read of the request register (offset 0x00C) returns the recorded bits and clears them. A second read with no new change returns zero.
- R4: A change in either direction on input i sets request bit i, where bit i corresponds to input i. This happens only while mask bit i (mask offset 0x018) is 1. A change on a masked-out input leaves the request register unchanged.
- R5: Unmasking an input that is already asserted does not by itself set its request bit.
- R6: The level register (offset 0x028) shows the synchronised level of all eleven inputs. Reading the request or pending register does not alter it.
- R7: The pending register (offset 0x01C) reads as the request bits AND the current mask, and reading it has no side effect.
- R8: A notification presents the target register (offset 0x004) as follows. The address is the target value with its low DATA_W (default 5) bits cleared. The data is those low bits, zero-extended. Address and data stay stable while `msg_valid` is high and `msg_ready` is low.
- R9: A notification is raised only while the request register is non-empty. After one is raised, no further one is raised until software has read the request register.
- R10: No notification is raised before the target register has been written at least once since reset.
- R11: While bit 0 of the control register (offset 0x024) is 1, notifications are held back. Clearing the bit releases a notification for requests that are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Asynchronous interrupt request lines |
| rq_valid | input | 1 | Register access strobe |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_addr | input | 12 | Register byte offset |
| rq_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| msg_valid | output | 1 | Notification write request |
| msg_ready | input | 1 | Notification accepted |
| msg_addr | output | 32 | Notification address |
| msg_data | output | 32 | Notification payload |

## Verification
A request bit that is lost or left stuck first appears on the next read of the request register. A stuck bit also shows as a missing or extra notification within about five cycles of the input change. An arming flag left in the wrong state shows as a second notification before any read, or as silence after a read followed by a new change. Both can be observed by counting accepted writes. A wrong synchroniser or edge memory shows as a request raised by unmasking alone, or as a falling edge that is never recorded, both within four cycles.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam logic [11:0] OFS_TARGET  = 12'h004;
  localparam logic [11:0] OFS_REQUEST = 12'h00C;
  localparam logic [11:0] OFS_MASK    = 12'h018;
  localparam logic [11:0] OFS_PENDING = 12'h01C;
  localparam logic [11:0] OFS_CONTROL = 12'h024;
  localparam logic [11:0] OFS_LEVEL   = 12'h028;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int N_IN   = 11,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] din,
  output logic [N_IN-1:0] level,
  output logic [N_IN-1:0] change
);
  for (genvar g = 0; g < N_IN; g++) begin : g_line
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[g]};
      prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
      end
    end

    assign level[g]  = chain_q[STAGES-1];
    assign change[g] = chain_q[STAGES-1] ^ prev_q;
  end
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
  parameter int              N_IN      = 11,
  parameter logic [N_IN-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] change,
  input  logic [N_IN-1:0] mask,
  input  logic            rd_clr,
  output logic [N_IN-1:0] req,
  output logic            nonempty
);
  logic [N_IN-1:0] req_q, req_d, new_bits;

  always_comb begin
    new_bits = change & mask & IMPL_MASK;
    if (rd_clr) req_d = new_bits;
    else        req_d = req_q | new_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req      = req_q;
  assign nonempty = |req_q;

  assert_impl_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q & ~IMPL_MASK) == '0);

  assert_masked_in_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q)) & ~$past(mask)) == '0);
endmodule

// File: rtl/irqagg_msg.sv
module irqagg_msg #(
  parameter int DATA_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] target,
  input  logic        target_ok,
  input  logic        hold,
  input  logic        have_req,
  input  logic        rearm,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [31:0] msg_addr,
  output logic [31:0] msg_data
);
  import irqagg_pkg::*;

  logic valid_q, valid_d;
  logic armed_q, armed_d;
  msg_t msg_q, msg_d;
  logic start, load_en;

  always_comb begin
    start   = !valid_q && armed_q && target_ok && !hold && have_req;
    load_en = start;
    msg_d   = msg_q;
    if (load_en) begin
      msg_d.addr = {target[31:DATA_W], {DATA_W{1'b0}}};
      msg_d.data = {{(32-DATA_W){1'b0}}, target[DATA_W-1:0]};
    end
    valid_d = valid_q;
    if (start)                  valid_d = 1'b1;
    else if (valid_q && msg_ready) valid_d = 1'b0;
    armed_d = armed_q;
    if (start)      armed_d = 1'b0;
    else if (rearm) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      armed_q <= 1'b1;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      armed_q <= armed_d;
      if (load_en) msg_q <= msg_d;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = msg_q.addr;
  assign msg_data  = msg_q.data;

  assert_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !msg_ready) |=> (valid_q && $stable(msg_q)));
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
  parameter int              N_IN      = 11,
  parameter logic [N_IN-1:0] IMPL_MASK = 11'h5FF,
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 5,
  parameter int              STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              rq_valid,
  input  logic              rq_write,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [31:0]       rq_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  import irqagg_pkg::*;
  localparam int PAD = 32 - N_IN;

  logic [N_IN-1:0] level, change, req, mask_q, mask_d;
  logic [31:0]     tgt_q, tgt_d, rdat_q, rdat_d;
  logic            tgt_ok_q, tgt_ok_d, ctrl_q, ctrl_d, rv_q, rv_d;
  logic            nonempty, wr, rd, rd_req;
  logic            sel_tgt, sel_req, sel_mask, sel_pend, sel_ctrl, sel_lvl;

  irqagg_sync #(.N_IN(N_IN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .level(level), .change(change)
  );

  irqagg_capture #(.N_IN(N_IN), .IMPL_MASK(IMPL_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .change(change), .mask(mask_q),
    .rd_clr(rd_req), .req(req), .nonempty(nonempty)
  );

  irqagg_msg #(.DATA_W(DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .target(tgt_q), .target_ok(tgt_ok_q),
    .hold(ctrl_q), .have_req(nonempty), .rearm(rd_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb begin
    wr       = rq_valid && rq_write;
    rd       = rq_valid && !rq_write;
    sel_tgt  = rq_addr == OFS_TARGET[ADDR_W-1:0];
    sel_req  = rq_addr == OFS_REQUEST[ADDR_W-1:0];
    sel_mask = rq_addr == OFS_MASK[ADDR_W-1:0];
    sel_pend = rq_addr == OFS_PENDING[ADDR_W-1:0];
    sel_ctrl = rq_addr == OFS_CONTROL[ADDR_W-1:0];
    sel_lvl  = rq_addr == OFS_LEVEL[ADDR_W-1:0];
    rd_req   = rd && sel_req;

    mask_d   = (wr && sel_mask) ? (rq_wdata[N_IN-1:0] & IMPL_MASK) : mask_q;
    tgt_d    = (wr && sel_tgt)  ? rq_wdata : tgt_q;
    tgt_ok_d = tgt_ok_q || (wr && sel_tgt);
    ctrl_d   = (wr && sel_ctrl) ? rq_wdata[0] : ctrl_q;

    rdat_d = '0;
    if (rd) begin
      if (sel_tgt)  rdat_d = tgt_q;
      if (sel_req)  rdat_d = {{PAD{1'b0}}, req};
      if (sel_mask) rdat_d = {{PAD{1'b0}}, mask_q};
      if (sel_pend) rdat_d = {{PAD{1'b0}}, req & mask_q};
      if (sel_ctrl) rdat_d = {31'b0, ctrl_q};
      if (sel_lvl)  rdat_d = {{PAD{1'b0}}, level};
    end
    rv_d = rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      tgt_q    <= '0;
      tgt_ok_q <= 1'b0;
      ctrl_q   <= 1'b0;
      rdat_q   <= '0;
      rv_q     <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      tgt_q    <= tgt_d;
      tgt_ok_q <= tgt_ok_d;
      ctrl_q   <= ctrl_d;
      rv_q     <= rv_d;
      if (rd) rdat_q <= rdat_d;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rdat_q;

  assert_target_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> tgt_ok_q);

  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(nonempty));
endmodule

// File: tb/tb_irq_msg_aggregator.sv
module tb_irq_msg_aggregator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] irq;
  logic        rq_valid, rq_write, msg_ready;
  logic [11:0] rq_addr;
  logic [31:0] rq_wdata, rd_data, msg_addr, msg_data;
  logic        rd_valid, msg_valid;
  int total = 0, bad = 0, msg_count = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_msg_aggregator dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .rq_valid(rq_valid),
    .rq_write(rq_write), .rq_addr(rq_addr), .rq_wdata(rq_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always @(posedge clk) if (rst_n && msg_valid && msg_ready) msg_count++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    rq_valid = 1; rq_write = 1; rq_addr = a; rq_wdata = d;
    @(negedge clk);
    rq_valid = 0; rq_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rq_valid = 1; rq_write = 0; rq_addr = a;
    @(negedge clk);
    rq_valid = 0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic set_line(int i, logic v);
    @(negedge clk);
    irq[i] = v;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 msg_valid", {31'b0, msg_valid}, 0);
    rd(12'h018, d); check("R1 mask", d, 0);
    rd(12'h00C, d); check("R1 request", d, 0);
    rd(12'h01C, d); check("R1 pending", d, 0);
    rd(12'h028, d); check("R1 level", d, 0);
  endtask

  task automatic t_mask_impl();
    logic [31:0] d;
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, d); check("R2 mask readback", d, 32'h5FF);
  endtask

  task automatic t_target();
    set_line(0, 1);
    check("R10 no message before target", {31'b0, msg_valid}, 0);
    check("R10 count", msg_count, 0);
    wr(12'h004, 32'h1234_5683);
    settle();
    check("R8 valid", {31'b0, msg_valid}, 1);
    check("R8 addr", msg_addr, 32'h1234_5680);
    check("R8 data", msg_data, 32'h0000_0003);
    repeat (4) @(negedge clk);
    check("R8 held", {31'b0, msg_valid}, 1);
    check("R8 addr held", msg_addr, 32'h1234_5680);
    msg_ready = 1;
    repeat (2) @(negedge clk);
    check("R8 accepted", msg_count, 1);
    check("R8 dropped", {31'b0, msg_valid}, 0);
  endtask

  task automatic t_one_per_read();
    logic [31:0] d;
    set_line(1, 1);
    check("R9 no second message", msg_count, 1);
    rd(12'h00C, d); check("R3 request", d, 32'h003);
    rd(12'h00C, d); check("R3 cleared", d, 0);
    settle();
    check("R9 empty no message", msg_count, 1);
    set_line(2, 1);
    check("R9 rearmed", msg_count, 2);
    rd(12'h00C, d); check("R4 rise", d, 32'h004);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    set_line(0, 0);
    check("R4 falling message", msg_count, 3);
    rd(12'h00C, d); check("R4 falling", d, 32'h001);
  endtask

  task automatic t_masked_out();
    logic [31:0] d;
    wr(12'h018, 32'h001);
    set_line(3, 1);
    check("R4 masked no message", msg_count, 3);
    rd(12'h00C, d); check("R4 masked request", d, 0);
    rd(12'h01C, d); check("R7 pending", d, 0);
    rd(12'h028, d); check("R6 level", d, {21'b0, irq});
    rd(12'h028, d); check("R6 level after reads", d, {21'b0, irq});
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    wr(12'h018, 32'h009);
    settle();
    check("R5 count", msg_count, 3);
    rd(12'h00C, d); check("R5 request", d, 0);
  endtask

  task automatic t_bits();
    logic [31:0] d;
    wr(12'h018, 32'h7FF);
    set_line(9, 1);
    check("R2 bit9 no message", msg_count, 3);
    rd(12'h00C, d); check("R2 bit9", d, 0);
    rd(12'h028, d); check("R6 level bit9", d, {21'b0, irq});
    set_line(10, 1);
    check("R4 bit10 message", msg_count, 4);
    rd(12'h00C, d); check("R4 bit10", d, 32'h400);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    set_line(4, 1);
    check("R7 message", msg_count, 5);
    rd(12'h01C, d); check("R7 pending", d, 32'h010);
    wr(12'h018, 32'h7EF);
    rd(12'h01C, d); check("R7 pending masked", d, 0);
    rd(12'h00C, d); check("R7 request kept", d, 32'h010);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(12'h024, 32'h1);
    rd(12'h024, d); check("R11 control", d, 1);
    set_line(5, 1);
    check("R11 held", msg_count, 5);
    wr(12'h024, 32'h0);
    settle();
    check("R11 released", msg_count, 6);
    rd(12'h00C, d); check("R11 request", d, 32'h020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq = '0; rq_valid = 0; rq_write = 0; rq_addr = '0;
    rq_wdata = '0; msg_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask_impl();
    t_target();
    t_one_per_read();
    t_falling();
    t_masked_out();
    t_unmask();
    t_bits();
    t_pending();
    t_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule